// File: doc/BRIEF.md
# Flash Word-Program Command Interface

This block models the command decoder and status register of a single flash partition, for programming one word at a time. A host issues bus write cycles made of an address, a data word and a write strobe. A two-write sequence, made of a setup code followed by the target address and its data, starts a behavioural write engine. That engine stays busy for a fixed number of clock cycles and then merges the data into a small on-block array.

Reads are combinational. Once a program sequence begins, reads return the status byte and no longer return array contents, until a read-array command switches them back. The host supplies two condition inputs: one flags a programming voltage at or below the lockout level, and the other is a lock bit for each block. Either condition makes the block refuse the program and record specific error bits.

For test purposes, a weak-bit mask stands in for cells that fail to program. This lets the verify step be exercised.

Top module: `flash_pgm_cui`

## Requirements
- R1: After reset the block is in array-read mode and every array word reads all ones (FFFFh).
- R2: A write of command 40h or 10h (in wdata[7:0]), followed by a write that carries the target address and data, programs that word. From the setup write onward, reads of any address return the status byte in rdata[7:0] with rdata[15:8] zero.
- R3: Status bit 7 reads 0 for exactly BUSY_CYC (8) clock cycles, counted from the data write, and then returns to 1.
- R4: Programming only clears bits. The stored word becomes old AND (data OR weak_bits), where weak_bits is sampled at the data write.
- R5: Status bit 4 is set when a bit whose data is 0 still reads 1 after programming. A bit that was already 0 while its data is 1 raises no error.
- R6: With vpp_low high at the data write, the array is left unchanged, no busy period occurs, and status bits 4 and 3 are set.
- R7: With the lock bit set for the target block (block index = addr[5:4]) at the data write, the array is left unchanged, no busy period occurs, and status bits 4 and 1 are set.
- R8: Error bits persist through later operations. Command 50h clears status bits 5, 4, 3 and 1 without changing the read mode.
- R9: Every write cycle that arrives while status bit 7 is 0 is ignored, including read-array and setup codes.
- R10: Command FFh returns reads to array mode. Other codes written outside a program sequence are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe, one cycle per bus write |
| addr | input | AW (6) | Word address for writes and reads |
| wdata | input | DW (16) | Write data, with the command code in bits 7:0 |
| vpp_low | input | 1 | Programming voltage at or below the lockout level |
| lock_mask | input | 2**BLKW (4) | Lock bit for each block |
| weak_bits | input | DW (16) | Bits that fail to program (fault model) |
| rdata | output | DW (16) | Status byte or array word, depending on the read mode |

## Verification
A clean program into erased cells checks the basic store, the status-mode read and the busy length. A second program over a partly cleared word, using the alternate setup code, shows that 0 bits never return to 1. It also shows that a 0-to-1 request is not reported as a verify error. A weak-bit mask then separates a true verify failure from a clean AND merge. Voltage-lockout and locked-block attempts each produce their own error-bit pair and leave the array unchanged. Further sequences confirm that errors persist until the clear command, that a locked block does not affect an unlocked one, and that writes during busy, including read-array, do not change the mode or the data.

// File: rtl/flash_pgm_cui.sv
module flash_pgm_cui #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int BLKW     = 2,
  parameter int BUSY_CYC = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   vpp_low,
  input  logic [(1<<BLKW)-1:0]   lock_mask,
  input  logic [DW-1:0]          weak_bits,
  output logic [DW-1:0]          rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BUSY_CYC + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DATA = 2'd1, S_BUSY = 2'd2} st_t;

  st_t             state;
  logic            stat_mode;
  logic [7:0]      sr;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   pa;
  logic [DW-1:0]   pd, pw;
  logic [DW-1:0]   mem [DEPTH];

  wire [7:0]      cmd    = wdata[7:0];
  wire            locked = lock_mask[addr[AW-1 -: BLKW]];
  wire [DW-1:0]   merged = mem[pa] & (pd | pw);
  wire            vfail  = |(merged & ~pd);

  assign rdata = stat_mode ? {{(DW-8){1'b0}}, sr} : mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stat_mode <= 1'b0;
      sr        <= 8'h80;
      cnt       <= '0;
      pa        <= '0;
      pd        <= '0;
      pw        <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      case (state)
        S_IDLE: if (we) begin
          case (cmd)
            8'h40, 8'h10: begin
              state     <= S_DATA;
              stat_mode <= 1'b1;
            end
            8'h50: begin
              sr[5] <= 1'b0;
              sr[4] <= 1'b0;
              sr[3] <= 1'b0;
              sr[1] <= 1'b0;
            end
            8'hFF: stat_mode <= 1'b0;
            default: ;
          endcase
        end
        S_DATA: if (we) begin
          stat_mode <= 1'b1;
          if (vpp_low) begin
            sr[4] <= 1'b1;
            sr[3] <= 1'b1;
            state <= S_IDLE;
          end else if (locked) begin
            sr[4] <= 1'b1;
            sr[1] <= 1'b1;
            state <= S_IDLE;
          end else begin
            pa    <= addr;
            pd    <= wdata;
            pw    <= weak_bits;
            cnt   <= CW'(BUSY_CYC - 1);
            sr[7] <= 1'b0;
            state <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (cnt == '0) begin
            mem[pa] <= merged;
            if (vfail) sr[4] <= 1'b1;
            sr[7] <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_pgm_cui_chk #(
  parameter int DW       = 16,
  parameter int CW       = 4,
  parameter int BUSY_CYC = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [DW-1:0] wdata,
  input logic          vpp_low,
  input logic          locked,
  input logic [1:0]    state,
  input logic [CW-1:0] cnt,
  input logic [7:0]    sr,
  input logic [DW-1:0] rdata
);
  a_r3_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && we && !vpp_low && !locked) |=> (!sr[7] && cnt == CW'(BUSY_CYC - 1)));
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && cnt != '0) |=> (state == 2'd2 && !sr[7]));
  a_r3_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && cnt == '0) |=> (state == 2'd0 && sr[7]));
  a_r2_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) |-> !rdata[7]);
  a_r6_vpp_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && we && vpp_low) |=> (sr[4] && sr[3] && sr[7] && state == 2'd0));
  a_r7_lock_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && we && !vpp_low && locked) |=> (sr[4] && sr[1] && sr[7] && state == 2'd0));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && we && wdata[7:0] == 8'h50) |=> (sr[5:3] == 3'b000 && !sr[1]));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && sr[4]) |=> sr[4]);
endmodule

bind flash_pgm_cui flash_pgm_cui_chk #(.DW(DW), .CW(CW), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata), .vpp_low(vpp_low),
  .locked(locked), .state(state), .cnt(cnt), .sr(sr), .rdata(rdata)
);

// File: tb/tb_flash_pgm_cui.sv
`timescale 1ns/1ps
module tb_flash_pgm_cui;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        vpp_low = 1'b0;
  logic [3:0]  lock_mask = '0;
  logic [15:0] weak_bits = '0;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        rd_ev;

  always #2.5 clk = ~clk;

  flash_pgm_cui dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .vpp_low(vpp_low), .lock_mask(lock_mask), .weak_bits(weak_bits), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string t, input logic [15:0] act, input logic [15:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  initial forever begin
    @(rd_ev);
    #1;
    chk(rdata === exp_q[0], tag_q[0], rdata, exp_q[0]);
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->rd_ev;
    #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic prog(input logic [5:0] a, input logic [7:0] c, input logic [15:0] d);
    wr(a, {8'h00, c});
    wr(a, d);
  endtask

  task automatic busy_len(input string t);
    int n = 0;
    while (!rdata[7] && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 8, t, 16'(n), 16'd8);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(6'd0,  16'hFFFF, "R1 erased word 0");
    rd(6'd63, 16'hFFFF, "R1 erased word 63");

    prog(6'd5, 8'h40, 16'hA5C3);
    busy_len("R3 busy length");
    rd(6'd5, 16'h0080, "R2 status read after program");
    wr(6'd0, 16'h00FF);
    rd(6'd5, 16'hA5C3, "R2 programmed word");

    prog(6'd5, 8'h10, 16'h0F0F);
    busy_len("R3 busy length alt code");
    rd(6'd5, 16'h0080, "R5 no error for 0-to-1 request");
    wr(6'd0, 16'h00FF);
    rd(6'd5, 16'h0503, "R4 AND merge");

    weak_bits = 16'h0010;
    prog(6'd9, 8'h40, 16'h0000);
    weak_bits = 16'h0000;
    busy_len("R3 busy length weak");
    rd(6'd9, 16'h0090, "R5 verify error");
    wr(6'd0, 16'h0050);
    rd(6'd9, 16'h0080, "R8 clear keeps status mode");
    wr(6'd0, 16'h00FF);
    rd(6'd9, 16'h0010, "R4 weak bit stays 1");

    vpp_low = 1'b1;
    prog(6'd12, 8'h40, 16'h0000);
    rd(6'd12, 16'h0098, "R6 voltage fault bits");
    vpp_low = 1'b0;
    wr(6'd0, 16'h00FF);
    rd(6'd12, 16'hFFFF, "R6 array unchanged");
    prog(6'd12, 8'h40, 16'h1234);
    busy_len("R3 busy length after fault");
    rd(6'd12, 16'h0098, "R8 errors sticky");
    wr(6'd0, 16'h0050);
    wr(6'd0, 16'h00FF);
    rd(6'd12, 16'h1234, "R8 program after fault");

    lock_mask = 4'b0100;
    prog(6'd40, 8'h40, 16'h0000);
    rd(6'd40, 16'h0092, "R7 lock fault bits");
    wr(6'd0, 16'h0050);
    rd(6'd40, 16'h0080, "R8 lock bits cleared");
    wr(6'd0, 16'h00FF);
    rd(6'd40, 16'hFFFF, "R7 locked word unchanged");
    prog(6'd20, 8'h40, 16'h5555);
    busy_len("R7 unlocked block busy");
    rd(6'd20, 16'h0080, "R7 unlocked block clean status");
    wr(6'd0, 16'h00FF);
    rd(6'd20, 16'h5555, "R7 unlocked block programmed");
    lock_mask = 4'b0000;

    prog(6'd50, 8'h40, 16'h00F0);
    wr(6'd50, 16'h00FF);
    wr(6'd50, 16'h0040);
    wr(6'd51, 16'h0000);
    repeat (10) @(negedge clk);
    rd(6'd50, 16'h0080, "R9 read-array ignored while busy");
    wr(6'd0, 16'h00FF);
    rd(6'd50, 16'h00F0, "R9 data unaffected");
    rd(6'd51, 16'hFFFF, "R9 setup ignored while busy");

    wr(6'd0, 16'h0023);
    rd(6'd5, 16'h0503, "R10 unknown code keeps array mode");
    wr(6'd0, 16'h0070);
    rd(6'd20, 16'h5555, "R10 second unknown code ignored");

    done = 1;
    summary();
    $finish;
  end
endmodule